// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral behind a simple 32-bit register port. A counter runs on the watchdog clock. When software fails to restart it in time, the counter first raises a timeout flag that can drive an interrupt. If the software still does nothing, a second interval later it raises a reset flag that can drive a reset request. The two intervals are powers of two and are programmed separately.

Software restarts the count with a two-write key sequence to the feed register. A key-protected lock register guards the control register against stray writes. A sleep input pauses the count unless software has chosen to keep the timer running in sleep. The bus has one write strobe and one read strobe. Read data arrives one cycle after the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, irq_o and rst_req_o are low, and the control, flags and enable registers read 0. The lock register reads 0, which means unlocked. The reserved word at byte offset 0x10 always reads 0, and every register ignores writes to its undefined bits, which read as 0.
- R2: Control at byte offset 0x00 holds bits [10:0] and reads them back. Bits [3:0] are the interrupt code, [7:4] the reset code, 8 is run, 9 is clock-on and 10 is keep-running-in-sleep. The enable register at 0x0C holds bit 0 (interrupt) and bit 2 (reset).
- R3: With run and clock-on both 1, the timeout flag (flags at 0x08, bit 0) sets 2^(25-code) cycles after the control write that starts the counter, where code is the interrupt code. irq_o rises one cycle after the flag, provided enable bit 0 is 1.
- R4: With no feed, the reset flag (flags bit 2) sets 2^(25-code) cycles after the timeout flag, where code is the reset code. rst_req_o rises one cycle later, provided enable bit 2 is 1.
- R5: Writing 0xA5 and then, as the very next bus write, 0x5A to the feed register at 0x04 restarts the count from zero in the interrupt phase. The timeout then comes a full interrupt interval after the 0x5A write.
- R6: Any other bus write between 0xA5 and 0x5A cancels the sequence, and a 0x5A write that does not follow an 0xA5 write has no effect on the count.
- R7: Writing 0x24 to the lock register at 0x14 locks it and 0x42 unlocks it. Other values change nothing. The register reads 1 while locked. While locked, control writes are ignored.
- R8: While run or clock-on is 0, the counter is held at zero in the interrupt phase and no flag sets. A later start counts a full interval from zero.
- R9: While sleep_i is high and control bit 10 is 0, the count pauses and the timeout is delayed by the paused cycles. With bit 10 set, sleep_i has no effect.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. irq_o and rst_req_o are the registered AND of each flag with its enable bit, so a cleared enable masks an output without touching the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sleep_i | input | 1 | System sleep indication |
| irq_o | output | 1 | Timeout interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
The interval logic is tested with several interrupt codes drawn at random. Sleep windows of random length are applied with the keep-running bit both clear and set. Each timeout is checked at the exact cycle, which separates an off-by-one in the terminal compare from a pause that fails to hold the count. Directed runs cover three feed cases: a correct feed, a feed interrupted by another write, and a stop and restart through the clock-on bit. A pure restart moves the deadline, while a broken sequence or a held counter leaves it where a fresh count would put it. The lock test and the masking test show that an ignored write leaves the read-back values and the outputs unchanged.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  // word index of each register (byte offset / 4)
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_FEED = 3'd1;
  localparam logic [2:0] IDX_FLAG = 3'd2;
  localparam logic [2:0] IDX_EN   = 3'd3;
  localparam logic [2:0] IDX_RSVD = 3'd4;
  localparam logic [2:0] IDX_LOCK = 3'd5;

  localparam logic [7:0] KEY_FEED_A = 8'hA5;
  localparam logic [7:0] KEY_FEED_B = 8'h5A;
  localparam logic [7:0] KEY_LOCK   = 8'h24;
  localparam logic [7:0] KEY_UNLOCK = 8'h42;

  localparam int CTRL_W = 11;

  typedef struct packed {
    logic       sleep_run; // bit 10
    logic       clk_on;    // bit 9
    logic       run_on;    // bit 8
    logic [3:0] rst_sel;   // bits 7:4
    logic [3:0] irq_sel;   // bits 3:0
  } ctrl_t;

  typedef enum logic [1:0] {PH_IRQ, PH_RST, PH_DONE} phase_e;
endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_tmo,
  input  logic              flag_rst,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              en_tmo,
  output logic              en_rst,
  output logic              clr_tmo,
  output logic              clr_rst,
  output logic              feed
);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0]   widx;
  logic              sel_ctrl, sel_feed, sel_flag, sel_en, sel_lock;
  logic              locked;
  logic              armed;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign widx     = addr[ADDR_W-1:2];
  assign sel_ctrl = (widx == WI_W'(IDX_CTRL));
  assign sel_feed = (widx == WI_W'(IDX_FEED));
  assign sel_flag = (widx == WI_W'(IDX_FLAG));
  assign sel_en   = (widx == WI_W'(IDX_EN));
  assign sel_lock = (widx == WI_W'(IDX_LOCK));
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CTRL_W]};

  // control register, write protected by the lock
  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr && sel_ctrl && !locked) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  // lock register: only the two keys change it
  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else if (wr && sel_lock) begin
      if (wdata[7:0] == KEY_LOCK) locked <= 1'b1;
      else if (wdata[7:0] == KEY_UNLOCK) locked <= 1'b0;
    end
  end

  // output enables
  always_ff @(posedge clk) begin
    if (rst) begin
      en_tmo <= 1'b0;
      en_rst <= 1'b0;
    end else if (wr && sel_en) begin
      en_tmo <= wdata[0];
      en_rst <= wdata[2];
    end
  end

  // feed key tracker: every write re-evaluates the armed state
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (wr) armed <= sel_feed && (wdata[7:0] == KEY_FEED_A);
  end

  assign feed    = wr && sel_feed && armed && (wdata[7:0] == KEY_FEED_B);
  assign clr_tmo = wr && sel_flag && wdata[0];
  assign clr_rst = wr && sel_flag && wdata[2];

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux[CTRL_W-1:0] = ctrl;
    if (sel_flag) begin
      rd_mux[0] = flag_tmo;
      rd_mux[2] = flag_rst;
    end
    if (sel_en) begin
      rd_mux[0] = en_tmo;
      rd_mux[2] = en_rst;
    end
    if (sel_lock) rd_mux[0] = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R7: a control write while locked leaves the register unchanged
  a_r7_locked_ctrl_held: assert property (@(posedge clk) disable iff (rst)
    (locked && wr && sel_ctrl) |=> $stable(ctrl));
endmodule

// File: rtl/wdg_counter.sv
`timescale 1ns/1ps
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int MAX_EXP = 25
) (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  sleep_i,
  input  logic  feed_i,
  output logic  tmo_hit_o,
  output logic  rst_hit_o
);
  localparam int CNT_W = MAX_EXP;
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  phase_e           phase;
  logic             hold, pause, step;
  logic [CNT_W-1:0] irq_last, rst_last;

  assign hold     = !(ctrl.run_on && ctrl.clk_on);
  assign pause    = sleep_i && !ctrl.sleep_run;
  assign step     = !hold && !feed_i && !pause;
  assign irq_last = ALL_ONES >> ctrl.irq_sel;
  assign rst_last = ALL_ONES >> ctrl.rst_sel;

  assign tmo_hit_o = step && (phase == PH_IRQ) && (cnt >= irq_last);
  assign rst_hit_o = step && (phase == PH_RST) && (cnt >= rst_last);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt   <= '0;
      phase <= PH_IRQ;
    end else if (feed_i) begin
      cnt   <= '0;
      phase <= PH_IRQ;
    end else if (!pause) begin
      case (phase)
        PH_IRQ: begin
          if (cnt >= irq_last) begin
            cnt   <= '0;
            phase <= PH_RST;
          end else cnt <= cnt + 1'b1;
        end
        PH_RST: begin
          if (cnt >= rst_last) begin
            cnt   <= '0;
            phase <= PH_DONE;
          end else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8: with run or clock-on off the counter sits at zero
  a_r8_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0) && (phase == PH_IRQ));
  // R9: a sleep pause freezes the count and the phase
  a_r9_pause_freezes: assert property (@(posedge clk) disable iff (rst)
    (!hold && !feed_i && pause) |=> $stable(cnt) && $stable(phase));
  // R5: a completed key sequence restarts from zero
  a_r5_feed_restarts: assert property (@(posedge clk) disable iff (rst)
    (feed_i && !hold) |=> (cnt == '0) && (phase == PH_IRQ));
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int MAX_EXP = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sleep_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t ctrl;
  logic  en_tmo, en_rst, clr_tmo, clr_rst, feed;
  logic  tmo_hit, rst_hit;
  logic  flag_tmo, flag_rst;

  wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .flag_tmo(flag_tmo), .flag_rst(flag_rst),
    .rdata(bus_rdata), .ctrl(ctrl), .en_tmo(en_tmo), .en_rst(en_rst),
    .clr_tmo(clr_tmo), .clr_rst(clr_rst), .feed(feed)
  );

  wdg_counter #(.MAX_EXP(MAX_EXP)) cnt_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sleep_i(sleep_i), .feed_i(feed),
    .tmo_hit_o(tmo_hit), .rst_hit_o(rst_hit)
  );

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_tmo <= 1'b0;
      flag_rst <= 1'b0;
    end else begin
      if (tmo_hit) flag_tmo <= 1'b1;
      else if (clr_tmo) flag_tmo <= 1'b0;
      if (rst_hit) flag_rst <= 1'b1;
      else if (clr_rst) flag_rst <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= flag_tmo && en_tmo;
      rst_req_o <= flag_rst && en_rst;
    end
  end

  // R10: outputs only rise behind an enabled bit
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(en_tmo));
  a_r10_rst_gated: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(en_rst));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sleep_i = 1'b0;
  logic        irq_o, rst_req_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  keyed_watchdog dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int span(input int code);
    return 1 << (25 - code);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic prep();
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h5);
    wr(5'h0C, 32'h5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int s, f, seed;
    seed = $urandom(32'd2718);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 rst_req_o", {31'b0, rst_req_o}, 0);
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h08, v); chk("R1 flags", v, 0);
    rd(5'h0C, v); chk("R1 enables", v, 0);
    rd(5'h14, v); chk("R1 lock", v, 0);

    // R2 register map read-back
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R2 ctrl mask", v, 32'h7FF);
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); chk("R2 enable mask", v, 32'h5);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); chk("R1 reserved", v, 0);

    // R3/R4 timeout then reset, codes 15/15
    prep();
    wr(5'h00, 32'h3FF); s = cyc;
    wait_to(s + span(15));     chk("R3 irq early", {31'b0, irq_o}, 0);
    wait_to(s + span(15) + 1); chk("R3 irq on time", {31'b0, irq_o}, 1);
    rd(5'h08, v); chk("R3 flag bit0", v, 32'h1);
    wait_to(s + 2 * span(15));     chk("R4 rst early", {31'b0, rst_req_o}, 0);
    wait_to(s + 2 * span(15) + 1); chk("R4 rst on time", {31'b0, rst_req_o}, 1);
    rd(5'h08, v); chk("R4 both flags", v, 32'h5);
    // R10 write-one-to-clear
    wr(5'h08, 32'h0); rd(5'h08, v); chk("R10 write zero keeps", v, 32'h5);
    wr(5'h08, 32'h1); rd(5'h08, v); chk("R10 clear bit0", v, 32'h4);
    chk("R10 irq drops", {31'b0, irq_o}, 0);
    chk("R10 rst kept", {31'b0, rst_req_o}, 1);

    // R5 feed restarts count, irq code 14
    prep();
    wr(5'h00, 32'h3FE); s = cyc;
    wait_to(s + 1500);
    wr(5'h04, 32'hA5); wr(5'h04, 32'h5A); f = cyc;
    wait_to(s + span(14) + 1); chk("R5 no timeout at old deadline", {31'b0, irq_o}, 0);
    wait_to(f + span(14));     chk("R5 irq early", {31'b0, irq_o}, 0);
    wait_to(f + span(14) + 1); chk("R5 irq after feed", {31'b0, irq_o}, 1);

    // R6 broken and lone keys
    prep();
    wr(5'h00, 32'h3FF); s = cyc;
    wait_to(s + 200);
    wr(5'h04, 32'hA5); wr(5'h0C, 32'h5); wr(5'h04, 32'h5A);
    wr(5'h04, 32'h5A);
    wait_to(s + span(15));     chk("R6 irq early", {31'b0, irq_o}, 0);
    wait_to(s + span(15) + 1); chk("R6 broken seq ignored", {31'b0, irq_o}, 1);

    // R7 lock
    prep();
    wr(5'h14, 32'h24); rd(5'h14, v); chk("R7 locked", v, 1);
    wr(5'h00, 32'h3FF); rd(5'h00, v); chk("R7 ctrl ignored", v, 0);
    wr(5'h14, 32'h11); rd(5'h14, v); chk("R7 other key", v, 1);
    wr(5'h14, 32'h42); rd(5'h14, v); chk("R7 unlocked", v, 0);
    wr(5'h00, 32'h0AB); rd(5'h00, v); chk("R7 ctrl written", v, 32'h0AB);

    // R8 hold when run or clock-on is clear
    prep();
    wr(5'h00, 32'h1FF); s = cyc;
    wait_to(s + span(15) + 20); chk("R8 no clk-on", {31'b0, irq_o}, 0);
    wr(5'h00, 32'h2FF); s = cyc;
    wait_to(s + span(15) + 20); chk("R8 no run", {31'b0, irq_o}, 0);
    rd(5'h08, v); chk("R8 flags clear", v, 0);
    wr(5'h00, 32'h3FF); s = cyc;
    wait_to(s + 600);
    wr(5'h00, 32'h1FF); wr(5'h00, 32'h3FF); s = cyc;
    wait_to(s + span(15));     chk("R8 restart early", {31'b0, irq_o}, 0);
    wait_to(s + span(15) + 1); chk("R8 restart full interval", {31'b0, irq_o}, 1);

    // R9 random sleep windows
    for (int i = 0; i < 4; i++) begin
      int code, keep, p, exp_t;
      code  = 13 + int'($urandom % 3);
      keep  = int'($urandom % 2);
      if (i < 2) keep = i;
      p     = 20 + int'($urandom % 200);
      exp_t = span(code) + (keep != 0 ? 0 : p);
      prep();
      wr(5'h00, 32'h3F0 | (keep << 10) | code); s = cyc;
      wait_to(s + 5);     sleep_i = 1'b1;
      wait_to(s + 5 + p); sleep_i = 1'b0;
      wait_to(s + exp_t);     chk("R9 irq early", {31'b0, irq_o}, 0);
      wait_to(s + exp_t + 1); chk("R9 irq after sleep", {31'b0, irq_o}, 1);
    end

    // R10 masking
    prep();
    wr(5'h0C, 32'h0);
    wr(5'h00, 32'h3FF); s = cyc;
    wait_to(s + span(15) + 10); chk("R10 masked irq", {31'b0, irq_o}, 0);
    rd(5'h08, v); chk("R10 flag still set", v[0], 1);
    wr(5'h0C, 32'h1);
    @(negedge clk); chk("R10 unmask", {31'b0, irq_o}, 1);

    finish_run();
  end
endmodule